// File: doc/BRIEF.md
# Single-Cycle RISC Core with Inequality Branch

A 32-bit processor that fetches, decodes, executes and retires one instruction per clock. It runs a small subset of a classic load/store instruction set: register-register add, subtract, and, or and signed set-less-than, plus add-immediate, word load, word store, branch-if-equal, branch-if-not-equal and an absolute jump. The core contains the program counter, a main decoder and an ALU decoder, a 32-entry register file, the ALU, the next-PC logic and a 64-word data memory.

The instruction store is outside the core. The core presents a word address every cycle and expects the instruction word back in the same cycle. Each retiring register write and each store is shown on observation ports, so the result of every instruction can be followed from outside.

The not-equal branch drives exactly the control word of the equal branch, which is a branch with the ALU subtracting. One opcode bit (instruction bit 26) then selects whether the taken condition is the ALU's zero flag or its not-zero flag.

Top module: `rcore_top`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 at the rising edge where reset is sampled high, and the fetch address is then 0.
- R2: The straight-line program 20110001 … 8C110008 leaves register 16 = 4, register 8 = 3, register 9 = 7, and stores 3, 4 and 4 to byte addresses 0x8, 0xC and 0x10.
- R3: R-type (opcode 000000) selects the operation from funct bits [5:0]. 100000 adds, 100010 subtracts, 100100 ANDs and 100101 ORs. 101010 gives 1 when the sign bit of rs−rt is set and 0 otherwise. The result goes to register rd (bits [15:11]).
- R4: ADDI (001000) writes rs plus the sign-extended 16-bit immediate to rt (bits [20:16]). SW (101011) and LW (100011) use the address rs plus the sign-extended offset. Data memory holds 64 words indexed by address bits [7:2]. A load returns the word last stored there.
- R5: BEQ (000100) is taken when rs equals rt. The next PC is then PC+4 plus the sign-extended immediate shifted left by 2, and a negative offset branches backward.
- R6: BNE (000101) is taken when rs differs from rt and uses the same target arithmetic. When not taken, it falls through to PC+4.
- R7: J (000010) sets the next PC to bits [31:28] of PC+4, followed by the 26-bit target, followed by two zero bits.
- R8: Register 0 always reads as zero. A write to it has no effect.
- R9: Without a taken branch or a jump, the PC advances by 4 each cycle. The fetch address is PC bits [7:2].
- R10: A register-writing instruction raises `wb_en` with the destination index and value in the same cycle. SW raises `st_en` with the address and data and never raises `wb_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Current program counter |
| imem_addr | output | 6 | Word address into the instruction store |
| imem_rdata | input | 32 | Instruction word for `imem_addr`, same cycle |
| wb_en | output | 1 | Current instruction writes a register |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Value written to the destination |
| st_en | output | 1 | Current instruction stores to data memory |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store data |

## Verification
Two things can fall in the same cycle: a register write that completes at an edge, and a branch whose comparison reads that same register on the very next cycle. In the branch program, a register is written by ADDI and then compared by BEQ or BNE immediately afterwards. In the loop program, a decrement is followed directly by a backward BNE on the decremented register. The outcome is judged from the fetch trace: which instruction slots execute, how often each one executes, and the values that appear on the writeback port.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int IMM_W  = 16;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LW    = 6'b100011;
    localparam logic [5:0] OPC_SW    = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_BNE   = 6'b000101;
    localparam logic [5:0] OPC_ADDI  = 6'b001000;
    localparam logic [5:0] OPC_J     = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // bit 2: invert b and carry in; bits [1:0]: result select
    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_ctl_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10,
        AOP_RSVD  = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic [5:0]        op;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } instr_t;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    src_imm;
        logic    branch;
        logic    mem_we;
        logic    load;
        logic    jump;
        alu_op_e aop;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext_imm(instr_t i);
        logic [IMM_W-1:0] imm;
        imm = {i.rd, i.shamt, i.funct};
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic logic [25:0] jump_field(instr_t i);
        return {i.rs, i.rt, i.rd, i.shamt, i.funct};
    endfunction

endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
    import rcore_pkg::*;
(
    input  instr_t   ins,
    output ctrl_t    ctl,
    output alu_ctl_e actl
);

    always_comb begin
        ctl = '0;
        case (ins.op)
            OPC_RTYPE: begin
                ctl.reg_we = 1'b1;
                ctl.dst_rd = 1'b1;
                ctl.aop    = AOP_FUNCT;
            end
            OPC_LW: begin
                ctl.reg_we  = 1'b1;
                ctl.src_imm = 1'b1;
                ctl.load    = 1'b1;
            end
            OPC_SW: begin
                ctl.src_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OPC_BEQ, OPC_BNE: begin
                ctl.branch = 1'b1;
                ctl.aop    = AOP_SUB;
            end
            OPC_ADDI: begin
                ctl.reg_we  = 1'b1;
                ctl.src_imm = 1'b1;
            end
            OPC_J: ctl.jump = 1'b1;
            default: ctl = '0;
        endcase
    end

    always_comb begin
        case (ctl.aop)
            AOP_ADD: actl = ALU_ADD;
            AOP_SUB: actl = ALU_SUB;
            default: begin
                case (ins.funct)
                    FN_ADD:  actl = ALU_ADD;
                    FN_SUB:  actl = ALU_SUB;
                    FN_AND:  actl = ALU_AND;
                    FN_OR:   actl = ALU_OR;
                    FN_SLT:  actl = ALU_SLT;
                    default: actl = ALU_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
    import rcore_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_ctl_e     ctl,
    output logic [W-1:0] y,
    output logic         zero,
    output logic         nonzero
);

    logic [W-1:0] b_eff;
    logic [W-1:0] sum;

    assign b_eff = ctl[2] ? ~b : b;
    assign sum   = a + b_eff + {{(W-1){1'b0}}, ctl[2]};

    always_comb begin
        case (ctl[1:0])
            2'b00:   y = a & b;
            2'b01:   y = a | b;
            2'b10:   y = sum;
            default: y = {{(W-1){1'b0}}, sum[W-1]};
        endcase
    end

    assign zero    = (y == '0);
    assign nonzero = ~zero;

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && (wa != '0)) regs[wa] <= wd;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/rcore_dmem.sv
module rcore_dmem #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/rcore_top.sv
module rcore_top
    import rcore_pkg::*;
#(
    parameter int IMEM_AW    = 6,
    parameter int DMEM_WORDS = 64,
    parameter int NREG       = 32
) (
    input  logic               clk,
    input  logic               rst,
    output logic [XLEN-1:0]    pc_o,
    output logic [IMEM_AW-1:0] imem_addr,
    input  logic [31:0]        imem_rdata,
    output logic               wb_en,
    output logic [REG_AW-1:0]  wb_idx,
    output logic [XLEN-1:0]    wb_data,
    output logic               st_en,
    output logic [XLEN-1:0]    st_addr,
    output logic [XLEN-1:0]    st_data
);

    localparam int DM_AW = $clog2(DMEM_WORDS);

    instr_t          ins;
    ctrl_t           ctl;
    alu_ctl_e        actl;
    logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_tgt, j_tgt;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, dm_rd, imm_x;
    logic [REG_AW-1:0] rs_idx, dst_idx;
    logic            alu_zero, alu_nz, take_br, jump_en, br_cond;

    assign ins = instr_t'(imem_rdata);

    // program counter
    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o      = pc_q;
    assign imem_addr = pc_q[IMEM_AW+1:2];

    rcore_decode u_dec (
        .ins  (ins),
        .ctl  (ctl),
        .actl (actl)
    );

    assign rs_idx  = ins.rs;
    assign dst_idx = ctl.dst_rd ? ins.rd : ins.rt;

    rcore_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
        .clk (clk),
        .we  (ctl.reg_we),
        .ra1 (ins.rs),
        .ra2 (ins.rt),
        .wa  (dst_idx),
        .wd  (wb_data),
        .rd1 (rs_val),
        .rd2 (rt_val)
    );

    assign imm_x = sext_imm(ins);
    assign alu_b = ctl.src_imm ? imm_x : rt_val;

    rcore_alu #(.W(XLEN)) u_alu (
        .a       (rs_val),
        .b       (alu_b),
        .ctl     (actl),
        .y       (alu_y),
        .zero    (alu_zero),
        .nonzero (alu_nz)
    );

    rcore_dmem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dm (
        .clk   (clk),
        .we    (ctl.mem_we),
        .idx   (alu_y[DM_AW+1:2]),
        .wdata (rt_val),
        .rdata (dm_rd)
    );

    // branch sense: opcode bit 26 picks the not-zero flag (BNE) over zero (BEQ)
    assign br_cond  = ins.op[0] ? alu_nz : alu_zero;
    assign take_br  = ctl.branch & br_cond;
    assign jump_en  = ctl.jump;

    assign pc_plus4 = pc_q + XLEN'(4);
    assign br_tgt   = pc_plus4 + {imm_x[XLEN-3:0], 2'b00};
    assign j_tgt    = {pc_plus4[XLEN-1:XLEN-4], jump_field(ins), 2'b00};

    always_comb begin
        if (jump_en)      pc_next = j_tgt;
        else if (take_br) pc_next = br_tgt;
        else              pc_next = pc_plus4;
    end

    assign wb_en   = ctl.reg_we;
    assign wb_idx  = dst_idx;
    assign wb_data = ctl.load ? dm_rd : alu_y;
    assign st_en   = ctl.mem_we;
    assign st_addr = alu_y;
    assign st_data = rt_val;

endmodule

// File: rtl/rcore_chk.sv
module rcore_chk
    import rcore_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc_o,
    input logic [31:0]     instr,
    input logic            wb_en,
    input logic            st_en,
    input logic            take_br,
    input logic            is_jump,
    input logic [4:0]      rs_idx,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val
);

    logic [XLEN-1:0] pc_p4;
    logic [XLEN-1:0] br_off;

    assign pc_p4  = pc_o + 32'd4;
    assign br_off = {{14{instr[15]}}, instr[15:0], 2'b00};

    AST_RESET_PC_ZERO: assert property (@(posedge clk)
        rst |=> (pc_o == '0)); // R1

    AST_PC_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!take_br && !is_jump) |=> (pc_o == $past(pc_p4))); // R9

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        take_br |=> (pc_o == $past(pc_p4 + br_off))); // R5

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        is_jump |=> (pc_o == {$past(pc_p4[31:28]), $past(instr[25:0]), 2'b00})); // R7

    AST_BEQ_SENSE: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_BEQ) |-> (take_br == (rs_val == rt_val))); // R5

    AST_BNE_SENSE: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_BNE) |-> (take_br == (rs_val != rt_val))); // R6

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == 5'd0) |-> (rs_val == '0)); // R8

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        !(st_en && wb_en)); // R10

endmodule

bind rcore_top rcore_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc_o    (pc_o),
    .instr   (imem_rdata),
    .wb_en   (wb_en),
    .st_en   (st_en),
    .take_br (take_br),
    .is_jump (jump_en),
    .rs_idx  (rs_idx),
    .rs_val  (rs_val),
    .rt_val  (rt_val)
);

// File: tb/rcore_top_tb.sv
module rcore_top_tb;

    localparam int CLK_P = 10;
    localparam int N_EXP = 41;

    // entry: {prog[51:48], kind[47:44], req[43:40], idx[39:32], value[31:0]}
    // kind 0 reg last value, 1 mem word, 2 exec count, 3 reg written flag, 4 store count
    localparam logic [51:0] EXP_TAB [N_EXP] = '{
        {4'd1, 4'd0, 4'd2,  8'd16, 32'd4},          // R2 $s0
        {4'd1, 4'd0, 4'd2,  8'd8,  32'd3},          // R2 $t0
        {4'd1, 4'd0, 4'd2,  8'd9,  32'd7},          // R2 $t1
        {4'd1, 4'd0, 4'd4,  8'd17, 32'd3},          // R4 reload
        {4'd1, 4'd1, 4'd4,  8'd0,  32'd1},          // R4
        {4'd1, 4'd1, 4'd4,  8'd1,  32'd2},          // R4
        {4'd1, 4'd1, 4'd2,  8'd2,  32'd3},          // R2
        {4'd1, 4'd1, 4'd2,  8'd3,  32'd4},          // R2
        {4'd1, 4'd1, 4'd2,  8'd4,  32'd4},          // R2
        {4'd1, 4'd2, 4'd9,  8'd12, 32'd1},          // R9
        {4'd1, 4'd4, 4'd10, 8'd0,  32'd5},          // R10
        {4'd2, 4'd0, 4'd6,  8'd20, 32'd4},          // R6
        {4'd2, 4'd0, 4'd5,  8'd9,  32'd9},          // R5
        {4'd2, 4'd0, 4'd6,  8'd17, 32'd4},          // R6
        {4'd2, 4'd2, 4'd6,  8'd3,  32'd0},          // R6 skipped
        {4'd2, 4'd2, 4'd6,  8'd4,  32'd1},          // R6
        {4'd2, 4'd2, 4'd5,  8'd7,  32'd0},          // R5 skipped
        {4'd2, 4'd2, 4'd5,  8'd8,  32'd0},          // R5 skipped
        {4'd2, 4'd2, 4'd5,  8'd9,  32'd1},          // R5
        {4'd2, 4'd3, 4'd6,  8'd19, 32'd0},          // R6
        {4'd2, 4'd3, 4'd5,  8'd18, 32'd0},          // R5
        {4'd2, 4'd2, 4'd6,  8'd11, 32'd1},          // R6 fall through
        {4'd3, 4'd0, 4'd3,  8'd3,  32'd8},          // R3 and
        {4'd3, 4'd0, 4'd3,  8'd4,  32'd14},         // R3 or
        {4'd3, 4'd0, 4'd3,  8'd5,  32'd1},          // R3 slt true
        {4'd3, 4'd0, 4'd3,  8'd6,  32'd0},          // R3 slt false
        {4'd3, 4'd0, 4'd3,  8'd8,  32'd1},          // R3 signed slt
        {4'd3, 4'd0, 4'd4,  8'd7,  32'hFFFF_FFFD},  // R4 sign extend
        {4'd3, 4'd0, 4'd8,  8'd9,  32'd0},          // R8
        {4'd3, 4'd0, 4'd3,  8'd12, 32'd2},          // R3 sub
        {4'd3, 4'd0, 4'd4,  8'd13, 32'd2},          // R4 load
        {4'd3, 4'd0, 4'd6,  8'd11, 32'd0},          // R6 loop end
        {4'd3, 4'd2, 4'd7,  8'd11, 32'd0},          // R7 skipped
        {4'd3, 4'd2, 4'd7,  8'd12, 32'd0},          // R7 skipped
        {4'd3, 4'd2, 4'd7,  8'd13, 32'd1},          // R7 landing
        {4'd3, 4'd2, 4'd6,  8'd14, 32'd3},          // R6 loop body
        {4'd3, 4'd2, 4'd6,  8'd15, 32'd3},          // R6 loop branch
        {4'd3, 4'd1, 4'd4,  8'd8,  32'd2},          // R4
        {4'd3, 4'd3, 4'd7,  8'd10, 32'd0},          // R7
        {4'd3, 4'd4, 4'd10, 8'd0,  32'd1},          // R10
        {4'd3, 4'd2, 4'd5,  8'd19, 32'd9}           // R5 self branch
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o;
    logic [5:0]  imem_addr;
    logic [31:0] imem_rdata;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic        st_en;
    logic [31:0] st_addr;
    logic [31:0] st_data;

    logic [31:0] prog [64];
    logic [31:0] obs_reg [32];
    logic [31:0] obs_mem [64];
    int          exec_cnt [64];
    bit          reg_wr [32];
    int          st_cnt;
    bit          tracking = 1'b0;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_P/2) clk = ~clk;

    assign imem_rdata = prog[imem_addr];

    rcore_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .pc_o       (pc_o),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .st_en      (st_en),
        .st_addr    (st_addr),
        .st_data    (st_data)
    );

    always @(negedge clk) begin
        if (tracking && !rst) begin
            exec_cnt[imem_addr] = exec_cnt[imem_addr] + 1;
            if (wb_en) begin
                obs_reg[wb_idx] = wb_data;
                reg_wr[wb_idx]  = 1'b1;
            end
            if (st_en) begin
                obs_mem[st_addr[7:2]] = st_data;
                st_cnt = st_cnt + 1;
            end
        end
    end

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'd0, fn};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_prog(int id);
        for (int i = 0; i < 64; i++) prog[i] = 32'h0;
        case (id)
            1: begin
                prog[0]  = 32'h20110001; prog[1]  = 32'h20120002;
                prog[2]  = 32'h20130003; prog[3]  = 32'h20140004;
                prog[4]  = 32'h02324020; prog[5]  = 32'h02744820;
                prog[6]  = 32'h01288022; prog[7]  = 32'hAC110000;
                prog[8]  = 32'hAC120004; prog[9]  = 32'hAC130008;
                prog[10] = 32'hAC14000C; prog[11] = 32'hAC100010;
                prog[12] = 32'h8C110008;
            end
            2: begin
                prog[0]  = 32'h20100001; prog[1]  = 32'h20110002;
                prog[2]  = 32'h16110001; prog[3]  = 32'h20130005;
                prog[4]  = 32'h20140004; prog[5]  = 32'h20080002;
                prog[6]  = 32'h11110002; prog[7]  = 32'h20120008;
                prog[8]  = 32'h02118820; prog[9]  = 32'h20090009;
                prog[10] = 32'h16280001; prog[11] = 32'h02308820;
                prog[12] = 32'h12300001; prog[13] = 32'h02308820;
            end
            default: begin
                prog[0]  = enc_i(6'b001000, 5'd0, 5'd1, 16'd12);
                prog[1]  = enc_i(6'b001000, 5'd0, 5'd2, 16'd10);
                prog[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100100);
                prog[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100101);
                prog[4]  = enc_r(5'd2, 5'd1, 5'd5, 6'b101010);
                prog[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'b101010);
                prog[6]  = enc_i(6'b001000, 5'd0, 5'd7, 16'hFFFD);
                prog[7]  = enc_r(5'd7, 5'd1, 5'd8, 6'b101010);
                prog[8]  = enc_i(6'b001000, 5'd0, 5'd0, 16'd5);
                prog[9]  = enc_r(5'd0, 5'd0, 5'd9, 6'b100000);
                prog[10] = {6'b000010, 26'd13};
                prog[11] = enc_i(6'b001000, 5'd0, 5'd10, 16'd1);
                prog[12] = enc_i(6'b001000, 5'd0, 5'd10, 16'd2);
                prog[13] = enc_i(6'b001000, 5'd0, 5'd11, 16'd3);
                prog[14] = enc_i(6'b001000, 5'd11, 5'd11, 16'hFFFF);
                prog[15] = enc_i(6'b000101, 5'd11, 5'd0, 16'hFFFE);
                prog[16] = enc_r(5'd1, 5'd2, 5'd12, 6'b100010);
                prog[17] = enc_i(6'b101011, 5'd0, 5'd12, 16'h0020);
                prog[18] = enc_i(6'b100011, 5'd0, 5'd13, 16'h0020);
                prog[19] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);
            end
        endcase
    endtask

    task automatic run_prog(int id);
        int ncyc;
        ncyc = (id == 1) ? 13 : (id == 2) ? 11 : 30;
        load_prog(id);
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        for (int i = 0; i < 64; i++) begin obs_mem[i] = 32'h0; exec_cnt[i] = 0; end
        for (int i = 0; i < 32; i++) begin obs_reg[i] = 32'h0; reg_wr[i] = 1'b0; end
        st_cnt   = 0;
        rst      = 1'b0;
        tracking = 1'b1;
        #2;
        check("R1 pc after reset", pc_o, 32'h0);
        check("R1 fetch addr after reset", {26'd0, imem_addr}, 32'h0);
        repeat (ncyc) @(negedge clk);
        #1 tracking = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cur;
        cur = 0;
        for (int e = 0; e < N_EXP; e++) begin
            int pid, kind, req, idx;
            logic [31:0] val, act;
            pid  = int'(EXP_TAB[e][51:48]);
            kind = int'(EXP_TAB[e][47:44]);
            req  = int'(EXP_TAB[e][43:40]);
            idx  = int'(EXP_TAB[e][39:32]);
            val  = EXP_TAB[e][31:0];
            if (pid != cur) begin
                run_prog(pid);
                cur = pid;
            end
            case (kind)
                0:       act = obs_reg[idx];
                1:       act = obs_mem[idx];
                2:       act = 32'(exec_cnt[idx]);
                3:       act = {31'd0, reg_wr[idx]};
                default: act = 32'(st_cnt);
            endcase
            check($sformatf("R%0d prog %0d kind %0d idx %0d", req, pid, kind, idx), act, val);
        end

        // R5: self branch holds the PC at word 19
        check("R5 self branch pc", pc_o, 32'd76);
        // R1: reset in the middle of execution
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1;
        check("R1 mid-run reset pc", pc_o, 32'h0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R9 step after reset", pc_o, 32'd4);
        @(posedge clk); #1;
        check("R9 second step", pc_o, 32'd8);
        check("R9 fetch addr follows pc", {26'd0, imem_addr}, 32'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule